// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Controller

This block takes display data from a processor, one byte at a time over an 8-bit bus, and keeps an eight-digit multiplexed LED display refreshed. Each byte is loaded in one of two modes, chosen per byte. In numeric mode the byte holds two packed BCD digits. Each digit is decoded into a seven-segment pattern, so one byte fills two digit positions, high nibble first. In annunciation mode the byte is used as it is, as a raw segment pattern for one digit. This lets the processor spell short words such as PASS, FAIL, O-F or U-CL with shapes the decoder cannot make.

A start-of-frame strobe sends the write position back to digit 0. Each later byte moves it forward. In a measurement frame the primary value's digits come first and the secondary value's digits follow. A free-running scan counter steps on a refresh tick. It drives a one-hot digit strobe and, from the same count, the read address of the register file. The segment output therefore always belongs to the strobed digit. The segment output is held in a register that loads only when the scan steps, so a write to the digit on display shows on that digit's next scan and never partway through a digit period.

Top module: `led_mux_ctrl`

## Requirements
- R1: After reset, digit_sel is 8'b0000_0001 (digit 0), seg_out is 8'h00, and every digit position holds the blank pattern 8'h00.
- R2: digit_sel always has exactly one bit set. Each cycle in which scan_tick is high moves it one bit toward the MSB, and after bit 7 it wraps back to bit 0.
- R3: In a cycle with scan_tick low, digit_sel and seg_out keep their values.
- R4: On the clock edge that advances the scan, seg_out loads the pattern stored for the newly selected digit. A write to the digit currently on display leaves seg_out unchanged until that digit is scanned again.
- R5: Segment bit order is {dp,g,f,e,d,c,b,a}, active high. In numeric mode BCD codes 0..9 decode to 3F,06,5B,4F,66,6D,7D,07,7F,6F (hex), with dp clear.
- R6: In numeric mode BCD codes 10..15 decode to the blank pattern 8'h00.
- R7: A numeric byte (mode=0) stores decode(wr_data[7:4]) at the write position and decode(wr_data[3:0]) at the next position, then advances the write position by two.
- R8: An annunciation byte (mode=1) stores wr_data unchanged as the pattern at the write position and advances it by one. The decoder output has no effect.
- R9: frame_start sets the write position to digit 0. A byte written in the same cycle is placed starting at digit 0.
- R10: A digit that would land beyond position 7 is dropped and leaves every stored pattern unchanged. A numeric byte at position 7 stores only its high digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Sets the write position back to digit 0 |
| wr_en | input | 1 | A byte is present on wr_data this cycle |
| mode | input | 1 | 0 = numeric (packed BCD), 1 = annunciation (raw pattern) |
| wr_data | input | 8 | Data byte from the processor |
| scan_tick | input | 1 | Refresh enable that steps the scan counter |
| digit_sel | output | 8 | One-hot digit strobe, bit n selects digit n |
| seg_out | output | 8 | Segment pattern {dp,g,f,e,d,c,b,a} for the strobed digit |

## Verification
The assertions expect frame_start, wr_en, mode and scan_tick to be clean single-cycle-sampled levels with no X after reset. The write-position assertions also expect a byte that arrives after the display is full to leave the position pinned at eight. The bench changes every input half a cycle away from the sampling edge and holds it for exactly one clock per byte or tick. It never drives X. It overfills the display on purpose, so that the saturated case is used and not just assumed. All stored contents are read back through the scan outputs, one full rotation of eight ticks at a time, and each read starts and ends on digit 0.

// File: rtl/disp_pkg.sv
// Shared types for the multiplexed display controller.
// Assumes segment order {dp,g,f,e,d,c,b,a}, active high.
package disp_pkg;
    localparam int SEG_W = 8;
    localparam int NIB_W = 4;

    typedef logic [SEG_W-1:0] seg_t;

    typedef enum logic {
        LOAD_NUMERIC = 1'b0,
        LOAD_ANNUN   = 1'b1
    } load_mode_e;
endpackage

// File: rtl/bcd_seg_decoder.sv
// Combinational BCD to seven-segment decoder.
// Assumes active-high segments in {dp,g,f,e,d,c,b,a} order; codes 10..15 blank.
module bcd_seg_decoder
    import disp_pkg::*;
(
    input  logic [NIB_W-1:0] bcd,
    output seg_t             seg
);
    // Map one BCD code to its segment pattern.
    always_comb begin
        case (bcd)
            4'd0:    seg = 8'h3F;
            4'd1:    seg = 8'h06;
            4'd2:    seg = 8'h5B;
            4'd3:    seg = 8'h4F;
            4'd4:    seg = 8'h66;
            4'd5:    seg = 8'h6D;
            4'd6:    seg = 8'h7D;
            4'd7:    seg = 8'h07;
            4'd8:    seg = 8'h7F;
            4'd9:    seg = 8'h6F;
            default: seg = 8'h00;
        endcase
    end
endmodule

// File: rtl/disp_loader.sv
// Write path: decodes or passes through each byte, picks the digit slots and
// keeps the auto-incrementing write position.
// Assumes at most one byte per cycle. The position saturates at NUM_DIGITS.
module disp_loader
    import disp_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    localparam int AW    = $clog2(NUM_DIGITS),
    localparam int PTR_W = $clog2(NUM_DIGITS + 3)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             wr_en,
    input  load_mode_e       mode,
    input  logic [7:0]       wr_data,
    output logic             we0,
    output logic [AW-1:0]    waddr0,
    output seg_t             wdata0,
    output logic             we1,
    output logic [AW-1:0]    waddr1,
    output seg_t             wdata1
);
    localparam int NIBS = 2;
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_DIGITS);

    seg_t             dec_seg [NIBS];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] base;
    logic [PTR_W-1:0] base_p1;
    logic [PTR_W-1:0] step_ptr;

    // One decoder per nibble; index 0 is the high nibble.
    for (genvar n = 0; n < NIBS; n++) begin : g_dec
        bcd_seg_decoder u_dec (
            .bcd (wr_data[(NIBS-1-n)*NIB_W +: NIB_W]),
            .seg (dec_seg[n])
        );
    end

    // Effective write position for this cycle.
    always_comb begin
        base     = frame_start ? '0 : ptr_q;
        base_p1  = base + PTR_W'(1);
        step_ptr = (mode == LOAD_NUMERIC) ? base + PTR_W'(2) : base_p1;
        if (step_ptr > PTR_END) step_ptr = PTR_END;
    end

    // Select the write ports according to the load mode.
    always_comb begin
        waddr0 = base[AW-1:0];
        waddr1 = base_p1[AW-1:0];
        we0    = wr_en && (base < PTR_END);
        if (mode == LOAD_NUMERIC) begin
            wdata0 = dec_seg[0];
            wdata1 = dec_seg[1];
            we1    = wr_en && (base_p1 < PTR_END);
        end else begin
            wdata0 = wr_data;
            wdata1 = '0;
            we1    = 1'b0;
        end
    end

    // Write position register.
    always_ff @(posedge clk) begin
        if (!rst_n)            ptr_q <= '0;
        else if (wr_en)        ptr_q <= step_ptr;
        else if (frame_start)  ptr_q <= '0;
    end

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_END);  // R10
    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !wr_en) |=> (ptr_q == '0));  // R9
    AST_ANNUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !frame_start && mode == LOAD_ANNUN && ptr_q < PTR_END)
        |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));  // R8
    AST_NUMERIC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !frame_start && mode == LOAD_NUMERIC && ptr_q + PTR_W'(1) < PTR_END)
        |=> (ptr_q == $past(ptr_q) + PTR_W'(2)));  // R7
endmodule

// File: rtl/disp_regfile.sv
// Display register file: one segment pattern per digit, two write ports and
// one combinational read port. Assumes the two write addresses differ
// whenever both ports are enabled.
module disp_regfile
    import disp_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    localparam int AW = $clog2(NUM_DIGITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we0,
    input  logic [AW-1:0] waddr0,
    input  seg_t          wdata0,
    input  logic          we1,
    input  logic [AW-1:0] waddr1,
    input  seg_t          wdata1,
    input  logic [AW-1:0] raddr,
    output seg_t          rdata
);
    seg_t mem [NUM_DIGITS];

    // Clear all entries on reset, else apply the write ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DIGITS; i++) mem[i] <= '0;
        end else begin
            if (we0) mem[waddr0] <= wdata0;
            if (we1) mem[waddr1] <= wdata1;
        end
    end

    // Read the entry addressed by the scan counter.
    always_comb rdata = mem[raddr];

    AST_PORTS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (we0 && we1) |-> (waddr0 != waddr1));  // R7
endmodule

// File: rtl/disp_scan.sv
// Scan counter with one-hot digit strobe and a held segment register.
// The read address is the next scan index, so the segment register loads the
// new digit's pattern on the same edge as the strobe moves.
module disp_scan
    import disp_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    localparam int AW = $clog2(NUM_DIGITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_tick,
    input  seg_t                  rd_seg,
    output logic [AW-1:0]         rd_idx,
    output logic [NUM_DIGITS-1:0] digit_sel,
    output seg_t                  seg_out
);
    localparam logic [AW-1:0] LAST = AW'(NUM_DIGITS - 1);

    logic [AW-1:0]         idx_q;
    logic [NUM_DIGITS-1:0] sel_rot;

    // Next index with wrap after the last digit.
    always_comb rd_idx = (idx_q == LAST) ? '0 : idx_q + AW'(1);

    // Advance the index and capture the new digit's pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            seg_out <= '0;
        end else if (scan_tick) begin
            idx_q   <= rd_idx;
            seg_out <= rd_seg;
        end
    end

    // One strobe line per digit, decoded from the index.
    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_strobe
        assign digit_sel[d] = (idx_q == AW'(d));
    end

    // Rotated copy of the strobe, used only by the check below.
    always_comb sel_rot = {digit_sel[NUM_DIGITS-2:0], digit_sel[NUM_DIGITS-1]};

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(digit_sel) == 1);  // R2
    AST_SCAN_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_tick |=> (digit_sel == $past(sel_rot)));  // R2
    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> ($stable(digit_sel) && $stable(seg_out)));  // R3
    AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        scan_tick |=> (seg_out == $past(rd_seg)));  // R4
endmodule

// File: rtl/led_mux_ctrl.sv
// Top of the multiplexed seven-segment display controller: loader, register
// file and scan stage. Assumes inputs are synchronous to clk.
module led_mux_ctrl
    import disp_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    localparam int AW = $clog2(NUM_DIGITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic                  wr_en,
    input  logic                  mode,
    input  logic [7:0]            wr_data,
    input  logic                  scan_tick,
    output logic [NUM_DIGITS-1:0] digit_sel,
    output logic [SEG_W-1:0]      seg_out
);
    logic          we0, we1;
    logic [AW-1:0] waddr0, waddr1, raddr;
    seg_t          wdata0, wdata1, rdata;
    load_mode_e    mode_e;

    // Interpret the raw mode pin.
    always_comb mode_e = load_mode_e'(mode);

    disp_loader #(.NUM_DIGITS(NUM_DIGITS)) u_loader (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_en(wr_en),
        .mode(mode_e), .wr_data(wr_data),
        .we0(we0), .waddr0(waddr0), .wdata0(wdata0),
        .we1(we1), .waddr1(waddr1), .wdata1(wdata1)
    );

    disp_regfile #(.NUM_DIGITS(NUM_DIGITS)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we0(we0), .waddr0(waddr0), .wdata0(wdata0),
        .we1(we1), .waddr1(waddr1), .wdata1(wdata1),
        .raddr(raddr), .rdata(rdata)
    );

    disp_scan #(.NUM_DIGITS(NUM_DIGITS)) u_scan (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .rd_seg(rdata),
        .rd_idx(raddr), .digit_sel(digit_sel), .seg_out(seg_out)
    );

    AST_RESET_STROBE: assert property (@(posedge clk)
        !rst_n |=> (digit_sel == NUM_DIGITS'(1) && seg_out == '0));  // R1
endmodule

// File: tb/led_mux_ctrl_tb.sv
module led_mux_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       wr_en = 1'b0;
    logic       mode = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       scan_tick = 1'b0;
    logic [7:0] digit_sel;
    logic [7:0] seg_out;

    int checks = 0;
    int failures = 0;
    logic [7:0] shown [8];

    always #2 clk = ~clk;

    led_mux_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_en(wr_en),
        .mode(mode), .wr_data(wr_data), .scan_tick(scan_tick),
        .digit_sel(digit_sel), .seg_out(seg_out)
    );

    // Numeric vectors: {byte, expected high digit, expected low digit}.
    localparam logic [23:0] VEC [8] = '{
        24'h01_3F_06, 24'h23_5B_4F, 24'h45_66_6D, 24'h67_7D_07,
        24'h89_7F_6F, 24'hA5_00_6D, 24'hBC_00_00, 24'h9F_6F_00
    };

    function automatic logic [7:0] exp_seg(input logic [3:0] b);
        case (b)
            4'd0: return 8'h3F; 4'd1: return 8'h06; 4'd2: return 8'h5B;
            4'd3: return 8'h4F; 4'd4: return 8'h66; 4'd5: return 8'h6D;
            4'd6: return 8'h7D; 4'd7: return 8'h07; 4'd8: return 8'h7F;
            4'd9: return 8'h6F; default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic fs, input logic md, input logic [7:0] d);
        @(negedge clk);
        frame_start = fs; wr_en = 1'b1; mode = md; wr_data = d;
        @(negedge clk);
        frame_start = 1'b0; wr_en = 1'b0;
    endtask

    // One tick, then sample; records the strobed digit's pattern.
    task automatic tick(output int idx);
        @(negedge clk); scan_tick = 1'b1;
        @(negedge clk); scan_tick = 1'b0;
        idx = -1;
        for (int i = 0; i < 8; i++) if (digit_sel[i]) idx = i;
        if (idx >= 0) shown[idx] = seg_out;
    endtask

    task automatic read_all();
        int idx;
        for (int k = 0; k < 8; k++) tick(idx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int idx;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobe", digit_sel, 8'h01);
        check("R1 seg", seg_out, 8'h00);
        read_all();
        for (int i = 0; i < 8; i++) check("R1 blank", shown[i], 8'h00);

        // Table walk: numeric decode of both nibbles (R5, R6, R7).
        for (int v = 0; v < 8; v++) begin
            put(1'b1, 1'b0, VEC[v][23:16]);
            read_all();
            check("R5/R6 high digit", shown[0], VEC[v][15:8]);
            check("R7 low digit", shown[1], VEC[v][7:0]);
        end

        // R3: no tick, nothing moves.
        held = seg_out;
        repeat (5) @(negedge clk);
        check("R3 strobe hold", digit_sel, 8'h01);
        check("R3 seg hold", seg_out, held);

        // R2: rotation and wrap.
        for (int k = 1; k <= 8; k++) begin
            tick(idx);
            check("R2 rotate", digit_sel, 8'(1 << (k % 8)));
        end

        // R8: raw patterns including dp and non-BCD shapes.
        put(1'b1, 1'b1, 8'h73); put(1'b0, 1'b1, 8'h77);
        put(1'b0, 1'b1, 8'h6D); put(1'b0, 1'b1, 8'h6D);
        put(1'b0, 1'b1, 8'hFF); put(1'b0, 1'b1, 8'h80);
        put(1'b0, 1'b1, 8'h05); put(1'b0, 1'b1, 8'h38);
        read_all();
        check("R8 raw0", shown[0], 8'h73);
        check("R8 raw3", shown[3], 8'h6D);
        check("R8 raw4", shown[4], 8'hFF);
        check("R8 raw5", shown[5], 8'h80);
        check("R8 raw6", shown[6], 8'h05);
        check("R8 raw7", shown[7], 8'h38);

        // R7/R8 mixed frame.
        put(1'b1, 1'b0, 8'h12); put(1'b0, 1'b1, 8'h40); put(1'b0, 1'b0, 8'h34);
        read_all();
        check("R7 mix0", shown[0], exp_seg(4'd1));
        check("R7 mix1", shown[1], exp_seg(4'd2));
        check("R8 mix2", shown[2], 8'h40);
        check("R7 mix3", shown[3], exp_seg(4'd3));
        check("R7 mix4", shown[4], exp_seg(4'd4));
        check("R8 keep5", shown[5], 8'h80);

        // R10: overfill with numeric bytes, extra byte dropped.
        put(1'b1, 1'b0, 8'h11); put(1'b0, 1'b0, 8'h22);
        put(1'b0, 1'b0, 8'h33); put(1'b0, 1'b0, 8'h44);
        put(1'b0, 1'b0, 8'h99); put(1'b0, 1'b1, 8'hAA);
        read_all();
        check("R10 pos0", shown[0], exp_seg(4'd1));
        check("R10 pos6", shown[6], exp_seg(4'd4));
        check("R10 pos7", shown[7], exp_seg(4'd4));

        // R10: numeric byte at position 7 stores only its high digit.
        put(1'b1, 1'b1, 8'h01);
        for (int k = 0; k < 6; k++) put(1'b0, 1'b1, 8'h01);
        put(1'b0, 1'b0, 8'h56);
        read_all();
        check("R10 high at 7", shown[7], exp_seg(4'd5));
        check("R10 no wrap", shown[0], 8'h01);

        // R9: frame_start together with a byte lands at digit 0.
        put(1'b0, 1'b1, 8'h11);
        put(1'b1, 1'b1, 8'h5C);
        read_all();
        check("R9 same cycle", shown[0], 8'h5C);
        check("R9 neighbour", shown[1], 8'h01);

        // R4: write to the digit on display, no change until its next scan.
        check("R4 on digit0", digit_sel, 8'h01);
        held = seg_out;
        put(1'b1, 1'b1, 8'h49);
        @(negedge clk);
        check("R4 no tearing", seg_out, held);
        read_all();
        check("R4 next scan", seg_out, 8'h49);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule